// File: doc/BRIEF.md
# Tag Check Fault Dispatcher

This block sits behind the tag comparison stage of a load/store pipeline. When a memory access fails its allocation-tag check, the pipeline presents one qualified event cycle. The event carries the control word that holds the check-mode fields, whether the access used a user-level translation regime, the access direction, the faulting virtual address, whether the regime splits the address space into two halves, and the current exception level.

From these inputs the block picks a 2-bit report mode and acts on it. It may ignore the event. It may issue a one-cycle synchronous abort request carrying the fault address and a write flag. It may set a sticky bit in the asynchronous fault status of the exception level concerned. In the mixed mode it handles stores asynchronously and loads synchronously. Software clears sticky bits through a per-bit clear input. Vector generation and syndrome encoding belong to the exception unit downstream.

Top module: `tag_fault_dispatch`

## Requirements
- R1: The report mode comes from control word bits [39:38] when `user_regime_i` is 1, and from bits [41:40] otherwise. No other control word bit has any effect.
- R2: Mode 1 (synchronous): in the cycle after the event, `abort_o` is 1 for exactly one cycle per event, with `abort_addr_o` equal to the event's address and `abort_write_o` equal to its `is_write_i`.
- R3: Mode 0 (off): an event produces no abort and leaves `async_status_o` unchanged.
- R4: Mode 2 (asynchronous): an event sets one status bit in the cycle after the event and raises no abort.
- R5: Mode 3 (mixed): a store event (`is_write_i`=1) behaves as in mode 2, and a load event behaves as in mode 1.
- R6: The status bit set for exception level e sits at position e*2+s of `async_status_o`. Here s is `fault_addr_i[55]` when `two_ranges_i` is 1, and s is 0 otherwise.
- R7: A status bit, once set, stays set until a cycle with its `clr_i` bit at 1, and that clear touches no other bit.
- R8: When a set and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: While reset is held, `abort_o`, `abort_addr_o`, `abort_write_o` and `async_status_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_valid_i | input | 1 | One tag-mismatch event this cycle |
| ctrl_word_i | input | CTRL_W | System control word holding both mode fields |
| user_regime_i | input | 1 | Access used a user-level translation regime |
| is_write_i | input | 1 | Access was a store |
| fault_addr_i | input | ADDR_W | Faulting virtual address |
| two_ranges_i | input | 1 | Regime has two address ranges |
| el_i | input | EL_W | Exception level whose status is updated |
| clr_i | input | NUM_EL*2 | Per-bit clear of the status bits |
| abort_o | output | 1 | Synchronous abort request pulse |
| abort_addr_o | output | ADDR_W | Address reported with the abort |
| abort_write_o | output | 1 | Write flag reported with the abort |
| async_status_o | output | NUM_EL*2 | Sticky asynchronous status, two bits per level |

## Verification
The properties assume that every input is meaningful only when `fault_valid_i` is 1 and that `el_i` stays below NUM_EL. They also assume that mode 0 events are dropped rather than forbidden. The stimulus always drives an in-range level. It holds the qualifier for exactly one cycle per event, except in the back-to-back case, where the single-cycle width of the abort is judged per event. A mode 0 event is still sent on purpose, to show that it leaves the outputs untouched. Each mode field is written with a different value from the other field, so selecting the wrong field changes the result.

// File: rtl/tag_fault_pkg.sv
package tag_fault_pkg;
  typedef enum logic [1:0] {
    TF_OFF   = 2'd0,
    TF_SYNC  = 2'd1,
    TF_ASYNC = 2'd2,
    TF_MIXED = 2'd3
  } tf_mode_e;

  typedef struct packed {
    logic take_sync;
    logic take_async;
  } tf_route_t;
endpackage

// File: rtl/tf_mode_pick.sv
module tf_mode_pick
  import tag_fault_pkg::*;
#(
  parameter int CTRL_W   = 64,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40
) (
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic              user_regime_i,
  output tf_mode_e          mode_o
);
  always_comb begin
    if (user_regime_i) mode_o = tf_mode_e'(ctrl_word_i[USER_LSB+:2]);
    else               mode_o = tf_mode_e'(ctrl_word_i[PRIV_LSB+:2]);
  end
endmodule

// File: rtl/tf_route.sv
module tf_route
  import tag_fault_pkg::*;
(
  input  logic      valid_i,
  input  tf_mode_e  mode_i,
  input  logic      is_write_i,
  output tf_route_t route_o
);
  always_comb begin
    route_o = '0;
    if (valid_i) begin
      unique case (mode_i)
        TF_SYNC:  route_o.take_sync  = 1'b1;
        TF_ASYNC: route_o.take_async = 1'b1;
        TF_MIXED: begin
          route_o.take_async = is_write_i;
          route_o.take_sync  = !is_write_i;
        end
        default:  route_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tf_status_bank.sv
module tf_status_bank #(
  parameter int NUM_EL = 4,
  localparam int EL_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1,
  localparam int ST_W = NUM_EL * 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [EL_W-1:0] set_el_i,
  input  logic            set_sel_i,
  input  logic [ST_W-1:0] clr_i,
  output logic [ST_W-1:0] status_o
);
  for (genvar e = 0; e < NUM_EL; e++) begin : g_el
    for (genvar b = 0; b < 2; b++) begin : g_bit
      logic hit, q;
      assign hit = set_i && (set_el_i == EL_W'(e)) && (set_sel_i == b[0]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q && !clr_i[e*2+b]) || hit;  // set beats clear
      end
      assign status_o[e*2+b] = q;
    end
  end
endmodule

// File: rtl/tf_abort_reg.sv
module tf_abort_reg #(
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  output logic              abort_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_o <= 1'b0;
      addr_o  <= '0;
      write_o <= 1'b0;
    end else begin
      abort_o <= fire_i;
      if (fire_i) begin
        addr_o  <= addr_i;
        write_o <= write_i;
      end
    end
  end
endmodule

// File: rtl/tag_fault_dispatch.sv
module tag_fault_dispatch
  import tag_fault_pkg::*;
#(
  parameter int CTRL_W   = 64,
  parameter int ADDR_W   = 64,
  parameter int NUM_EL   = 4,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40,
  parameter int SEL_BIT  = 55,
  localparam int EL_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1,
  localparam int ST_W = NUM_EL * 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_valid_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic              user_regime_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] fault_addr_i,
  input  logic              two_ranges_i,
  input  logic [EL_W-1:0]   el_i,
  input  logic [ST_W-1:0]   clr_i,
  output logic              abort_o,
  output logic [ADDR_W-1:0] abort_addr_o,
  output logic              abort_write_o,
  output logic [ST_W-1:0]   async_status_o
);
  tf_mode_e  mode;
  tf_route_t route;
  logic      sel;

  tf_mode_pick #(.CTRL_W(CTRL_W), .USER_LSB(USER_LSB), .PRIV_LSB(PRIV_LSB)) u_pick (
    .ctrl_word_i  (ctrl_word_i),
    .user_regime_i(user_regime_i),
    .mode_o       (mode)
  );

  tf_route u_route (
    .valid_i   (fault_valid_i),
    .mode_i    (mode),
    .is_write_i(is_write_i),
    .route_o   (route)
  );

  assign sel = two_ranges_i && fault_addr_i[SEL_BIT];

  tf_status_bank #(.NUM_EL(NUM_EL)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (route.take_async),
    .set_el_i (el_i),
    .set_sel_i(sel),
    .clr_i    (clr_i),
    .status_o (async_status_o)
  );

  tf_abort_reg #(.ADDR_W(ADDR_W)) u_abort (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (route.take_sync),
    .addr_i (fault_addr_i),
    .write_i(is_write_i),
    .abort_o(abort_o),
    .addr_o (abort_addr_o),
    .write_o(abort_write_o)
  );
endmodule

// File: rtl/tag_fault_dispatch_chk.sv
module tag_fault_dispatch_chk #(
  parameter int CTRL_W   = 64,
  parameter int ADDR_W   = 64,
  parameter int NUM_EL   = 4,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40,
  parameter int SEL_BIT  = 55,
  localparam int EL_W = (NUM_EL > 1) ? $clog2(NUM_EL) : 1,
  localparam int ST_W = NUM_EL * 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fault_valid_i,
  input logic [CTRL_W-1:0] ctrl_word_i,
  input logic              user_regime_i,
  input logic              is_write_i,
  input logic [ADDR_W-1:0] fault_addr_i,
  input logic              two_ranges_i,
  input logic [EL_W-1:0]   el_i,
  input logic [ST_W-1:0]   clr_i,
  input logic              abort_o,
  input logic [ADDR_W-1:0] abort_addr_o,
  input logic              abort_write_o,
  input logic [ST_W-1:0]   async_status_o
);
  logic [1:0]      m;
  logic            want_sync, want_async;
  logic [ST_W-1:0] exp_set, exp_q, keep_q, prev_q;

  assign m = user_regime_i ? ctrl_word_i[USER_LSB+:2] : ctrl_word_i[PRIV_LSB+:2];
  assign want_sync  = fault_valid_i && (m == 2'd1 || (m == 2'd3 && !is_write_i));
  assign want_async = fault_valid_i && (m == 2'd2 || (m == 2'd3 && is_write_i));

  always_comb begin
    for (int i = 0; i < ST_W; i++)
      exp_set[i] = want_async &&
                   (i == int'(el_i) * 2 + ((two_ranges_i && fault_addr_i[SEL_BIT]) ? 1 : 0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q  <= '0;
      keep_q <= '0;
      prev_q <= '0;
    end else begin
      exp_q  <= exp_set;
      keep_q <= async_status_o & ~clr_i;
      prev_q <= async_status_o;
    end
  end

  assert_sync_abort_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    want_sync |=> abort_o && abort_addr_o == $past(fault_addr_i) && abort_write_o == $past(is_write_i));

  assert_no_spurious_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !want_sync |=> !abort_o);

  assert_async_no_abort_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    want_async |=> !abort_o);

  // R6 / R8: the expected bit is set even under a simultaneous clear
  assert_async_bit_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_status_o & exp_q) == exp_q);

  assert_only_expected_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_status_o & ~prev_q & ~exp_q) == '0);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_status_o & keep_q) == keep_q);

  assert_single_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(async_status_o & ~prev_q) <= 1);
endmodule

bind tag_fault_dispatch tag_fault_dispatch_chk #(
  .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .NUM_EL(NUM_EL),
  .USER_LSB(USER_LSB), .PRIV_LSB(PRIV_LSB), .SEL_BIT(SEL_BIT)
) u_chk (.*);

// File: tb/tag_fault_dispatch_test.sv
module tag_fault_dispatch_test;
  localparam int CTRL_W = 64;
  localparam int ADDR_W = 64;
  localparam int NUM_EL = 4;
  localparam int EL_W   = 2;
  localparam int ST_W   = 8;

  typedef struct packed {
    logic       user;
    logic [1:0] mu;
    logic [1:0] mk;
    logic       wr;
    logic       two;
    logic       a55;
    logic [1:0] el;
    logic       x_abort;
    logic [7:0] x_stat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h00},
    '{1'b0, 2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 8'h08},
    '{1'b1, 2'd2, 2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 8'h02},
    '{1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 8'h00},
    '{1'b0, 2'd2, 2'd3, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 8'h10},
    '{1'b0, 2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1, 8'h00},
    '{1'b1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 8'h40},
    '{1'b1, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 8'h00},
    '{1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 8'h00},
    '{1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 8'h40},
    '{1'b0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 8'h80}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              fault_valid_i = 1'b0;
  logic [CTRL_W-1:0] ctrl_word_i = '0;
  logic              user_regime_i = 1'b0;
  logic              is_write_i = 1'b0;
  logic [ADDR_W-1:0] fault_addr_i = '0;
  logic              two_ranges_i = 1'b0;
  logic [EL_W-1:0]   el_i = '0;
  logic [ST_W-1:0]   clr_i = '0;
  logic              abort_o;
  logic [ADDR_W-1:0] abort_addr_o;
  logic              abort_write_o;
  logic [ST_W-1:0]   async_status_o;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #5 clk_i = ~clk_i;

  tag_fault_dispatch uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ctrl(input logic [1:0] mu, input logic [1:0] mk);
    logic [63:0] c;
    c = 64'hDEAD_BEEF_1234_5678 & ~(64'hF << 38);
    c[39:38] = mu;
    c[41:40] = mk;
    return c;
  endfunction

  // drive one event at a negedge; returns at the following negedge with valid low
  task automatic send(input logic user, input logic [1:0] mu, input logic [1:0] mk,
                      input logic wr, input logic two, input logic [63:0] addr,
                      input logic [1:0] el);
    @(negedge clk_i);
    fault_valid_i = 1'b1;
    ctrl_word_i   = mk_ctrl(mu, mk);
    user_regime_i = user;
    is_write_i    = wr;
    two_ranges_i  = two;
    fault_addr_i  = addr;
    el_i          = el;
    @(negedge clk_i);
    fault_valid_i = 1'b0;
  endtask

  task automatic clear_all();
    clr_i = '1;
    @(negedge clk_i);
    clr_i = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    repeat (3) @(negedge clk_i);
    check(abort_o == 0 && abort_addr_o == 0 && abort_write_o == 0, "R9 abort reset", {63'd0, abort_o}, 0);
    check(async_status_o == 0, "R9 status reset", async_status_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      a = 64'h0012_3456_789A_BC00 + 64'(i * 16);
      a[55] = VECS[i].a55;
      send(VECS[i].user, VECS[i].mu, VECS[i].mk, VECS[i].wr, VECS[i].two, a, VECS[i].el);
      check(abort_o == VECS[i].x_abort, $sformatf("R1/R2/R3/R5 vec%0d abort", i), {63'd0, abort_o}, {63'd0, VECS[i].x_abort});
      if (VECS[i].x_abort) begin
        check(abort_addr_o == a, $sformatf("R2 vec%0d addr", i), abort_addr_o, a);
        check(abort_write_o == VECS[i].wr, $sformatf("R2 vec%0d write", i), {63'd0, abort_write_o}, {63'd0, VECS[i].wr});
      end
      check(async_status_o == VECS[i].x_stat, $sformatf("R4/R6 vec%0d status", i), async_status_o, {56'd0, VECS[i].x_stat});
      clear_all();
      check(abort_o == 0, $sformatf("R2 vec%0d pulse width", i), {63'd0, abort_o}, 0);
      check(async_status_o == 0, $sformatf("R7 vec%0d clear", i), async_status_o, 0);
    end

    // R7: sticky, partial clear touches nothing else
    b = 64'h0080_0000_0000_0040;
    send(1'b0, 2'd0, 2'd2, 1'b0, 1'b1, b, 2'd1);       // bit 3
    send(1'b0, 2'd0, 2'd2, 1'b0, 1'b0, b, 2'd2);       // bit 4
    repeat (5) @(negedge clk_i);
    check(async_status_o == 8'h18, "R7 sticky idle", async_status_o, 8'h18);
    clr_i = 8'h08;
    @(negedge clk_i);
    clr_i = '0;
    check(async_status_o == 8'h10, "R7 partial clear", async_status_o, 8'h10);
    clear_all();

    // R8: set and clear on same bit in same cycle
    @(negedge clk_i);
    fault_valid_i = 1'b1;
    ctrl_word_i   = mk_ctrl(2'd2, 2'd0);
    user_regime_i = 1'b1;
    is_write_i    = 1'b1;
    two_ranges_i  = 1'b0;
    el_i          = 2'd0;
    clr_i         = 8'h01;
    @(negedge clk_i);
    fault_valid_i = 1'b0;
    clr_i         = '0;
    check(async_status_o == 8'h01, "R8 set wins", async_status_o, 8'h01);
    clear_all();

    // R2: back-to-back synchronous events give one pulse each
    a = 64'h0000_1111_2222_3330;
    b = 64'h0000_4444_5555_6660;
    @(negedge clk_i);
    fault_valid_i = 1'b1;
    ctrl_word_i   = mk_ctrl(2'd0, 2'd1);
    user_regime_i = 1'b0;
    is_write_i    = 1'b1;
    fault_addr_i  = a;
    @(negedge clk_i);
    is_write_i    = 1'b0;
    fault_addr_i  = b;
    check(abort_o == 1 && abort_addr_o == a && abort_write_o == 1, "R2 first of pair", abort_addr_o, a);
    @(negedge clk_i);
    fault_valid_i = 1'b0;
    check(abort_o == 1 && abort_addr_o == b && abort_write_o == 0, "R2 second of pair", abort_addr_o, b);
    @(negedge clk_i);
    check(abort_o == 0, "R2 pair ends", {63'd0, abort_o}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule